// File: doc/BRIEF.md
# Shared-Clock Serial Converter Sequencer

This block is the host side of a 10-bit serial analog-to-digital converter that has eleven multiplexed inputs and one clock line. That single line serves the converter as both its I/O clock and its conversion clock. The sequencer produces that line by dividing the system clock, and it keeps the line running at all times. It frames each transfer with an active-low select. It shifts the 4-bit channel number out, shifts the previous conversion back in, and times the instant at which the converter stops tracking its input.

A frame starts on a falling edge of the line. The first two line cycles only let the converter recognise the select, and they carry no address. Ten valid cycles follow. The address goes out MSB first during the first four valid cycles. The select returns high on the falling edge of the tenth valid cycle, so the line has exactly twelve rising edges while the select is low. The converter holds its sample on that last falling edge and then converts, using the line as its clock while the select is high. The converter only returns the conversion during the next frame, so every accepted request runs two frames: an address frame and a readout frame that sends the same address again. The select stays high for a conversion wait after each frame. When strobe mode is selected, the first frame holds the line high through its tenth valid cycle. The line falls, and the hold happens, at the first system edge that samples the strobe input high.

States of the controller: `ST_IDLE` waits for a request. `ST_ARM` waits for the next falling edge of the line. `ST_DUMMY` runs the two recognition cycles. `ST_SHIFT` runs the ten valid cycles. `ST_STALL` keeps the line high until the strobe arrives. `ST_WAIT` counts the conversion time. The transitions are as follows. IDLE→ARM on an accepted request. ARM→DUMMY on a falling edge, which also lowers the select. DUMMY→SHIFT on the second recognition falling edge. SHIFT→STALL on the tenth valid rising edge of the address frame when strobe mode is selected. SHIFT→WAIT and STALL→WAIT on the final falling edge, which also raises the select. WAIT→ARM after the address frame. WAIT→IDLE after the readout frame, which delivers the result.

Top module: `adc_shared_clk_seq`

## Requirements
- R1: After reset the select is high, the line is low, and busy, result_valid and chan_err are all low.
- R2: While no frame holds the line, it runs freely with a period of 2*CLK_HALF system cycles.
- R3: A request whose channel is above 10 gives a chan_err pulse of one cycle. It starts no frame and leaves busy low.
- R4: The select falls together with a falling edge of the line. Each frame has exactly 12 rising edges of the line while the select is low: 2 recognition cycles and then 10 valid cycles. The select rises on the same system edge as the 12th falling edge.
- R5: The channel goes out on adc_addr MSB first, one bit per valid cycle for valid cycles 1 to 4, and it is stable across every rising edge. Both frames of a request carry the requested channel.
- R6: Each accepted request runs exactly two frames. During the 10 valid cycles of the second frame, adc_dout is sampled MSB first on each rising edge. The 10 sampled bits are presented on result.
- R7: Between frames the select stays high for at least CONV_WAIT system cycles.
- R8: In strobe mode the line stays high after the tenth valid rising edge of the first frame for as long as strobe is low. It falls, and the select rises, on the first system edge that samples strobe high, once at least CLK_HALF cycles have passed.
- R9: busy rises on the edge after an accepted request and falls on the edge where result_valid rises. result_valid lasts one cycle, and result holds its value until the next result.
- R10: Without strobe mode, the select rises exactly CLK_HALF system cycles after the tenth valid rising edge.
- R11: A request raised while busy is ignored. The frames in progress keep the original channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request a conversion |
| req_chan | input | CH_W | Channel to convert (0 to 10 valid) |
| strobe_mode | input | 1 | Time the hold instant to strobe |
| strobe | input | 1 | Hold-instant trigger in strobe mode |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_clk | output | 1 | Shared I/O and conversion clock line |
| adc_addr | output | 1 | Serial channel address to the converter |
| busy | output | 1 | Request in progress |
| result | output | RES_W | Converted value |
| result_valid | output | 1 | One-cycle pulse when result updates |
| chan_err | output | 1 | One-cycle pulse on a rejected channel |

## Verification
The bench builds the block with CLK_HALF=2 and CONV_WAIT=40. With these values the line period is 4 system cycles and a two-frame request takes a few hundred cycles, so dozens of random requests fit in the run. The short half period also lets strobe delays of only a few cycles reach past the point where an unstalled line would already have fallen. A converter model in the bench ties each conversion value to the channel it captured and to the exact hold instant, so a wrong edge count, a misplaced hold or a swapped bit all show up in result.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_DUMMY,
        ST_SHIFT,
        ST_STALL,
        ST_WAIT
    } seq_state_e;
endpackage

// File: rtl/scs_clkgen.sv
`timescale 1ns/1ps
module scs_clkgen #(
    parameter int CLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_high,
    output logic sclk,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          due;

    assign due     = (cnt_q == LAST);
    assign rise_ev = due && !sclk;
    assign fall_ev = due && sclk && !hold_high;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk  <= 1'b0;
            cnt_q <= '0;
        end else if (rise_ev || fall_ev) begin
            sclk  <= ~sclk;
            cnt_q <= '0;
        end else if (!due) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scs_addr_tx.sv
`timescale 1ns/1ps
module scs_addr_tx #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] val,
    output logic         bit_o
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            bit_o  <= 1'b0;
        end else if (load) begin
            bit_o  <= val[W-1];
            sreg_q <= val << 1;
        end else if (adv) begin
            bit_o  <= sreg_q[W-1];
            sreg_q <= sreg_q << 1;
        end
    end
endmodule

// File: rtl/scs_rx_shift.sv
`timescale 1ns/1ps
module scs_rx_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clr) begin
            word <= '0;
        end else if (en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/scs_frame_fsm.sv
`timescale 1ns/1ps
module scs_frame_fsm
    import scs_pkg::*;
#(
    parameter int CH_W      = 4,
    parameter int NUM_CH    = 11,
    parameter int RES_W     = 10,
    parameter int DUMMY_CYC = 2,
    parameter int CONV_WAIT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] chan_in,
    input  logic            strobe_mode,
    input  logic            strobe,
    input  logic            rise_ev,
    input  logic            fall_ev,
    output logic            clk_hold,
    output logic            cs_n,
    output logic            busy,
    output logic            chan_err,
    output logic            addr_load,
    output logic            addr_adv,
    output logic            rx_clr,
    output logic            rx_en,
    output logic            fin_now,
    output logic [CH_W-1:0] chan_q
);
    localparam int CW = $clog2(RES_W + DUMMY_CYC + 1);
    localparam int WW = (CONV_WAIT > 1) ? $clog2(CONV_WAIT + 1) : 1;
    localparam logic [CW-1:0] LAST_VALID = CW'(RES_W - 1);
    localparam logic [CW-1:0] LAST_DUMMY = CW'(DUMMY_CYC - 1);
    localparam logic [WW-1:0] LAST_WAIT  = WW'(CONV_WAIT - 1);

    seq_state_e      state_q, state_d;
    logic [CW-1:0]   cyc_q;
    logic [WW-1:0]   wait_q;
    logic            pass_q;
    logic            smode_q;
    logic            chan_ok;
    logic            last_valid, last_dummy, wait_done;

    assign chan_ok    = (int'(chan_in) < NUM_CH);
    assign last_valid = (cyc_q == LAST_VALID);
    assign last_dummy = (cyc_q == LAST_DUMMY);
    assign wait_done  = (wait_q == LAST_WAIT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && chan_ok) state_d = ST_ARM;
            ST_ARM:   if (fall_ev) state_d = ST_DUMMY;
            ST_DUMMY: if (fall_ev && last_dummy) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (rise_ev && last_valid && smode_q && !pass_q)
                    state_d = ST_STALL;
                else if (fall_ev && last_valid)
                    state_d = ST_WAIT;
            end
            ST_STALL: if (fall_ev) state_d = ST_WAIT;
            ST_WAIT:  if (wait_done) state_d = pass_q ? ST_IDLE : ST_ARM;
            default:  state_d = ST_IDLE;
        endcase
    end

    // strobes to the datapath
    always_comb begin
        clk_hold  = (state_q == ST_STALL) && !strobe;
        addr_load = (state_q == ST_DUMMY) && fall_ev && last_dummy;
        addr_adv  = ((state_q == ST_SHIFT) || (state_q == ST_STALL)) && fall_ev;
        rx_clr    = (state_q == ST_ARM) && fall_ev && pass_q;
        rx_en     = (state_q == ST_SHIFT) && rise_ev && pass_q;
        fin_now   = (state_q == ST_WAIT) && wait_done && pass_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            wait_q  <= '0;
            pass_q  <= 1'b0;
            smode_q <= 1'b0;
            chan_q  <= '0;
        end else begin
            if (state_d != state_q)
                cyc_q <= '0;
            else if (fall_ev && ((state_q == ST_DUMMY) || (state_q == ST_SHIFT)))
                cyc_q <= cyc_q + 1'b1;

            if (state_q != ST_WAIT) wait_q <= '0;
            else if (!wait_done)    wait_q <= wait_q + 1'b1;

            if (state_q == ST_IDLE && state_d == ST_ARM) begin
                pass_q  <= 1'b0;
                smode_q <= strobe_mode;
                chan_q  <= chan_in;
            end else if (state_q == ST_WAIT && state_d == ST_ARM) begin
                pass_q  <= 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n     <= 1'b1;
            busy     <= 1'b0;
            chan_err <= 1'b0;
        end else begin
            cs_n     <= !((state_d == ST_DUMMY) || (state_d == ST_SHIFT) ||
                          (state_d == ST_STALL));
            busy     <= (state_d != ST_IDLE);
            chan_err <= (state_q == ST_IDLE) && start && !chan_ok;
        end
    end
endmodule

// File: rtl/adc_shared_clk_seq.sv
`timescale 1ns/1ps
module adc_shared_clk_seq #(
    parameter int CLK_HALF  = 4,
    parameter int CONV_WAIT = 64,
    parameter int CH_W      = 4,
    parameter int NUM_CH    = 11,
    parameter int RES_W     = 10,
    parameter int DUMMY_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [CH_W-1:0]  req_chan,
    input  logic             strobe_mode,
    input  logic             strobe,
    input  logic             adc_dout,
    output logic             adc_cs_n,
    output logic             adc_clk,
    output logic             adc_addr,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             chan_err
);
    logic             rise_ev, fall_ev, clk_hold;
    logic             addr_load, addr_adv, rx_clr, rx_en, fin_now;
    logic [CH_W-1:0]  chan_q;
    logic [RES_W-1:0] rx_word;

    scs_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .hold_high(clk_hold),
        .sclk(adc_clk), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    scs_frame_fsm #(
        .CH_W(CH_W), .NUM_CH(NUM_CH), .RES_W(RES_W),
        .DUMMY_CYC(DUMMY_CYC), .CONV_WAIT(CONV_WAIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(req_start), .chan_in(req_chan),
        .strobe_mode(strobe_mode), .strobe(strobe),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .clk_hold(clk_hold),
        .cs_n(adc_cs_n), .busy(busy), .chan_err(chan_err),
        .addr_load(addr_load), .addr_adv(addr_adv), .rx_clr(rx_clr),
        .rx_en(rx_en), .fin_now(fin_now), .chan_q(chan_q)
    );

    scs_addr_tx #(.W(CH_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(addr_load), .adv(addr_adv),
        .val(chan_q), .bit_o(adc_addr)
    );

    scs_rx_shift #(.W(RES_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .en(rx_en),
        .din(adc_dout), .word(rx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= fin_now;
            if (fin_now) result <= rx_word;
        end
    end
endmodule

// File: rtl/scs_seq_checker.sv
`timescale 1ns/1ps
module scs_seq_checker #(
    parameter int FRAME_EDGES = 12
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic addr,
    input logic busy,
    input logic res_valid,
    input logic chan_err,
    input logic clk_hold
);
    logic       prev_sclk;
    logic [5:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sclk <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            prev_sclk <= sclk;
            if (cs_n)
                rise_cnt <= '0;
            else if (sclk && !prev_sclk && rise_cnt != 6'h3f)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    assert_frame_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_cnt == 6'(FRAME_EDGES)));
    assert_no_extra_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (rise_cnt <= 6'(FRAME_EDGES)));
    assert_cs_fall_on_clk_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $fell(sclk));
    assert_cs_rise_on_clk_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $fell(sclk));
    assert_addr_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk)) |-> $stable(addr));
    assert_hold_keeps_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |-> sclk);
    assert_hold_next_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |=> sclk);
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_valid_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!busy && $past(busy)));
    assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err |-> (!busy && cs_n));
endmodule

bind adc_shared_clk_seq scs_seq_checker #(.FRAME_EDGES(DUMMY_CYC + RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .sclk(adc_clk),
    .addr(adc_addr), .busy(busy), .res_valid(result_valid),
    .chan_err(chan_err), .clk_hold(clk_hold)
);

// File: tb/tb_adc_shared_clk_seq.sv
`timescale 1ns/1ps
module tb_adc_shared_clk_seq;
    localparam int HALF = 2;
    localparam int CWAIT = 40;
    localparam real TCK = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic [3:0] req_chan = '0;
    logic       strobe_mode = 1'b0;
    logic       strobe = 1'b0;
    logic       adc_dout = 1'b0;
    logic       adc_cs_n, adc_clk, adc_addr, busy, result_valid, chan_err;
    logic [9:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_shared_clk_seq #(.CLK_HALF(HALF), .CONV_WAIT(CWAIT)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_chan(req_chan),
        .strobe_mode(strobe_mode), .strobe(strobe), .adc_dout(adc_dout),
        .adc_cs_n(adc_cs_n), .adc_clk(adc_clk), .adc_addr(adc_addr),
        .busy(busy), .result(result), .result_valid(result_valid),
        .chan_err(chan_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int tick_of(input realtime t);
        return int'((t - 2.5) / TCK);
    endfunction

    function automatic logic [9:0] model_code(input logic [3:0] a, input int tk);
        return 10'((int'(a) * 97 + tk * 13) % 1024);
    endfunction

    // converter model
    int         rises = 0;
    int         fcount = 0;
    logic [3:0] addr_cap = '0;
    logic [3:0] cur_chan = '0;
    logic [9:0] conv_data = '0;
    realtime    last_rise_t = 0, last_hold_t = 0, hold_rise_t = 0, up_t = 0;
    bit         have_up = 0;

    always @(negedge adc_cs_n) begin
        rises = 0;
        addr_cap = '0;
        adc_dout <= conv_data[9];
        if (have_up) // R7
            chk(($realtime - up_t) >= CWAIT * TCK - 0.1, "R7",
                longint'(($realtime - up_t) / TCK), CWAIT);
    end

    always @(posedge adc_clk) begin
        if (!adc_cs_n) begin
            rises++;
            last_rise_t = $realtime;
            if (rises >= 3 && rises <= 6) addr_cap = {addr_cap[2:0], adc_addr};
            if (rises >= 3 && rises <= 11) adc_dout <= conv_data[9 - (rises - 2)];
        end
    end

    always @(posedge adc_cs_n) begin
        if (rst_n) begin
            last_hold_t = $realtime;
            hold_rise_t = last_rise_t;
            chk(rises == 12, "R4", rises, 12);
            chk(addr_cap == cur_chan, "R5", addr_cap, cur_chan);
            conv_data = model_code(addr_cap, tick_of($realtime));
            fcount++;
            up_t = $realtime;
            have_up = 1;
        end
    end

    task automatic run_req(input int ch, input bit smode, input int sdly, input bit poke);
        int f0;
        int n;
        int h1;
        realtime st_t;
        logic [9:0] exp;
        cur_chan = 4'(ch);
        f0 = fcount;
        @(negedge clk);
        req_chan = 4'(ch); strobe_mode = smode; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, "R9", busy, 1);
        if (poke) begin // R11: second request while busy
            n = 0;
            while (adc_cs_n && n < 2000) begin @(negedge clk); n++; end
            req_chan = 4'((ch + 3) % 11); req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
            req_chan = 4'(ch);
        end
        if (smode) begin
            n = 0;
            while (!(rises == 12 && adc_clk && !adc_cs_n) && n < 5000) begin
                @(negedge clk); n++;
            end
            repeat (sdly) begin
                @(negedge clk);
                chk(adc_clk == 1'b1, "R8", adc_clk, 1);
            end
            strobe = 1'b1;
            st_t = $realtime + 2.5;
            n = 0;
            while (fcount == f0 && n < 5000) begin @(negedge clk); n++; end
            strobe = 1'b0;
            chk((last_hold_t > st_t - 0.1) && (last_hold_t < st_t + 0.1), "R8",
                tick_of(last_hold_t), tick_of(st_t));
        end else begin
            n = 0;
            while (fcount == f0 && n < 5000) begin @(negedge clk); n++; end
            chk((last_hold_t - hold_rise_t) > HALF * TCK - 0.1 &&
                (last_hold_t - hold_rise_t) < HALF * TCK + 0.1, "R10",
                longint'((last_hold_t - hold_rise_t) / TCK), HALF);
        end
        h1 = tick_of(last_hold_t);
        exp = model_code(4'(ch), h1);
        n = 0;
        while (!result_valid && n < 20000) begin
            @(negedge clk); n++;
            if (!result_valid && busy !== 1'b1) begin
                chk(0, "R9", busy, 1);
                break;
            end
        end
        chk(result_valid == 1'b1, "R9", result_valid, 1);
        chk(result == exp, "R6", result, exp);
        chk(busy == 1'b0, "R9", busy, 0);
        chk(fcount - f0 == 2, "R6", fcount - f0, 2);
        @(negedge clk);
        chk(result_valid == 1'b0, "R9", result_valid, 0);
        chk(result == exp, "R9", result, exp);
        if (poke) begin // R11: nothing more happens
            f0 = fcount;
            repeat (60) @(negedge clk);
            chk(fcount == f0 && adc_cs_n && !busy, "R11", fcount - f0, 0);
        end
    endtask

    task automatic err_req(input int ch);
        int f0;
        f0 = fcount;
        @(negedge clk);
        req_chan = 4'(ch); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(chan_err == 1'b1, "R3", chan_err, 1);
        chk(busy == 1'b0, "R3", busy, 1'b0);
        @(negedge clk);
        chk(chan_err == 1'b0, "R3", chan_err, 0);
        repeat (30) @(negedge clk);
        chk(fcount == f0 && adc_cs_n && !busy, "R3", fcount - f0, 0);
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(150000 * TCK);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9: watchdog expired busy=%0d expected=0", busy);
            report();
            $finish;
        end
    end

    initial begin
        realtime t1, t2;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1
        chk(adc_cs_n == 1'b1, "R1", adc_cs_n, 1);
        chk(adc_clk == 1'b0, "R1", adc_clk, 0);
        chk(busy == 1'b0 && result_valid == 1'b0 && chan_err == 1'b0, "R1",
            {busy, result_valid, chan_err}, 0);
        rst_n = 1'b1;
        // R2
        @(posedge adc_clk); t1 = $realtime;
        @(posedge adc_clk); t2 = $realtime;
        chk((t2 - t1) > 2 * HALF * TCK - 0.1 && (t2 - t1) < 2 * HALF * TCK + 0.1, "R2",
            longint'((t2 - t1) / TCK), 2 * HALF);

        // directed corners
        run_req(0, 0, 0, 0);
        run_req(10, 0, 0, 0);
        run_req(5, 1, 2, 0);
        run_req(10, 1, 9, 0);
        err_req(11);
        err_req(15);
        run_req(7, 0, 0, 1);
        run_req(3, 1, 4, 1);

        // random mix
        for (int i = 0; i < 24; i++) begin
            int ch;
            int sm;
            int dl;
            ch = int'($urandom % 16);
            sm = int'($urandom % 2);
            dl = 2 + int'($urandom % 7);
            if (ch > 10) err_req(ch);
            else run_req(ch, sm[0], dl, 1'b0);
            repeat (int'($urandom % 9)) @(negedge clk);
        end

        finished = 1;
        report();
        $finish;
    end
endmodule